// File: doc/BRIEF.md
# Page Re-encryption Status Tracker

This block keeps the bookkeeping for encryption pages that must be re-encrypted after one of their per-block counters wraps. It holds a small set of status entries. Each entry owns one page for the duration of its re-encryption and records three things: the page number, the major counter value the page was encrypted under before the wrap, and one completion flag per block on the page. Normal cache traffic keeps flowing while pages are in progress. Demand accesses and arriving memory fills consult the tracker to learn whether a block still needs the old counter.

On allocation the tracker takes the free entry with the lowest index. The same accept pulse tells the counter store to advance that page's major counter. A sequencer then walks every block of each active page, one block per cycle, and round-robins between active entries. For each block it asks the cache whether the block is present. A present block is told to become dirty, which re-encrypts it lazily on its next write-back, and is counted complete at once. An absent block gets a memory fetch. When that fetch returns, the tracker hands back the saved old major counter for decryption and flags the block for a counter reset and an immediate write-back that bypasses the cache. An entry frees itself once all its blocks are complete.

Top module: `reenc_tracker`

## Requirements
- R1: An accepted allocation always lands in the free entry with the lowest index; slots are numbered 0 to 7.
- R2: An accepted allocation (alloc_accept high, which is also the command to advance the page's major counter) makes the entry valid, stores the page and the supplied old major counter, and clears every completion flag.
- R3: The sequencer visits a page's blocks in ascending index order from block 0, one block per cycle. When the cache reports the visited block as present, mark_dirty is raised, no fetch is issued, and that block's flag is set.
- R4: When the cache reports the visited block as absent, fetch_issue is raised for that page and block, and the block's flag stays clear.
- R5: A fill whose page matches a valid entry and whose block flag is clear raises fill_redo in the same cycle, with fill_major carrying the saved old counter, and sets the flag. A fill for an unknown page or for a block already complete leaves fill_redo low.
- R6: The cycle after an entry's last flag is set, the entry is invalid and lookups of its page miss.
- R7: A demand lookup that hits a block whose flag is clear raises lk_wait. A block whose flag is set proceeds, with lk_wait low.
- R8: An allocation request stalls, and changes no state, when all eight entries are valid or when a valid entry already holds the same page.
- R9: The sequencer round-robins among entries that are still walking their pages, so any eight consecutive visits with eight active entries cover all eight.
- R10: A lookup returns hit, slot index, the block's flag and the saved major counter combinationally, in the same cycle as the page and block are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Request to start re-encrypting a page |
| alloc_page | input | PAGE_W | Page number to re-encrypt |
| alloc_major | input | MAJ_W | Major counter value before the increment |
| alloc_accept | output | 1 | Request taken; also advances the page's major counter |
| alloc_stall | output | 1 | Request refused this cycle (full or duplicate page) |
| alloc_slot | output | IDX_W | Entry chosen for the request |
| probe_valid | output | 1 | A block is being probed in the cache this cycle |
| probe_page | output | PAGE_W | Page of the probed block |
| probe_blk | output | BLK_W | Block index of the probed block |
| probe_hit | input | 1 | Cache reports the probed block present |
| mark_dirty | output | 1 | Cache must set the probed block dirty |
| fetch_issue | output | 1 | Memory fetch of the probed block is requested |
| fill_valid | input | 1 | A fetched block is arriving |
| fill_page | input | PAGE_W | Page of the arriving block |
| fill_blk | input | BLK_W | Block index of the arriving block |
| fill_redo | output | 1 | Decrypt with old counter, reset minor counter, write back without caching |
| fill_slot | output | IDX_W | Entry matching the fill page |
| fill_major | output | MAJ_W | Saved old major counter for the fill |
| lk_page | input | PAGE_W | Demand lookup page |
| lk_blk | input | BLK_W | Demand lookup block |
| lk_hit | output | 1 | Page is under re-encryption |
| lk_slot | output | IDX_W | Entry holding the page |
| lk_done | output | 1 | Block already re-encrypted |
| lk_major | output | MAJ_W | Saved old major counter |
| lk_wait | output | 1 | Demand access must wait for the block's fill |

## Verification
The probe sequencer and the fill path can both set completion flags of the same entry in one cycle. A probe marks a present block while a fetch for an earlier absent block returns. The bench provokes this by driving a fill for block 1 exactly when the sequencer visits cached block 4 of the same page. It judges the result by checking that mark_dirty and fill_redo are both high in that cycle, and that lookups afterwards report both blocks complete. Release also relies on this merge: the last flag may come from either source, and the bench confirms the entry drops out only after the final fill.

// File: rtl/rt_pkg.sv
// Shared defaults for the page re-encryption tracker.
// Assumes nothing; only constants used as parameter defaults.
package rt_pkg;
    localparam int RT_ENTRIES = 8;
    localparam int RT_BLOCKS  = 64;
    localparam int RT_PAGE_W  = 20;
    localparam int RT_MAJOR_W = 64;
endpackage

// File: rtl/rt_match.sv
// Parallel page-tag comparator over all entries.
// Assumes at most one valid entry carries a given tag (duplicates are refused at allocation).
module rt_match #(
    parameter int N      = 8,
    parameter int TAG_W  = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    // compare key against every valid tag and encode the matching slot
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && tags[i] == key) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rt_pick.sv
// Lowest-index picker and rotating picker, chosen by ROTATE.
// Assumes N is at least 2; with ROTATE the search starts just after 'last'.
module rt_pick #(
    parameter int N      = 8,
    parameter bit ROTATE = 1'b0,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    generate
        if (ROTATE) begin : g_rr
            // search from last+1 round the ring; nearest requester wins
            always_comb begin
                int j;
                any = 1'b0;
                idx = '0;
                for (int k = N; k >= 1; k--) begin
                    j = (int'(last) + k) % N;
                    if (req[j]) begin
                        any = 1'b1;
                        idx = IDX_W'(j);
                    end
                end
            end
        end else begin : g_low
            // fixed priority: lowest set bit wins
            always_comb begin
                any = 1'b0;
                idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (req[i]) begin
                        any = 1'b1;
                        idx = IDX_W'(i);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rt_entry.sv
// One re-encryption status entry: page tag, saved major counter, per-block
// completion flags, and the probe pointer for walking the page.
// Assumes BLKS is a power of two and alloc_we only targets an invalid entry.
module rt_entry #(
    parameter int BLKS   = 64,
    parameter int PAGE_W = 20,
    parameter int MAJ_W  = 64,
    localparam int BLK_W = $clog2(BLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_we,
    input  logic [PAGE_W-1:0] alloc_page,
    input  logic [MAJ_W-1:0]  alloc_major,
    input  logic              probe_go,
    input  logic              probe_hit,
    input  logic              fill_set,
    input  logic [BLK_W-1:0]  fill_blk,
    output logic              valid,
    output logic [PAGE_W-1:0] tag,
    output logic [MAJ_W-1:0]  major,
    output logic [BLKS-1:0]   done,
    output logic              scanning,
    output logic [BLK_W-1:0]  ptr
);
    logic [BLKS-1:0] done_nxt;

    // merge flag updates from the probe and the fill path
    always_comb begin
        done_nxt = done;
        if (probe_go && probe_hit) done_nxt[ptr] = 1'b1;
        if (fill_set)              done_nxt[fill_blk] = 1'b1;
    end

    // entry state: allocate, advance probe pointer, record flags, release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            scanning <= 1'b0;
            tag      <= '0;
            major    <= '0;
            done     <= '0;
            ptr      <= '0;
        end else if (alloc_we) begin
            valid    <= 1'b1;
            scanning <= 1'b1;
            tag      <= alloc_page;
            major    <= alloc_major;
            done     <= '0;
            ptr      <= '0;
        end else if (valid) begin
            done <= done_nxt;
            if (probe_go) begin
                ptr <= ptr + 1'b1;
                if (ptr == BLK_W'(BLKS - 1)) scanning <= 1'b0;
            end
            if (&done_nxt) begin
                valid    <= 1'b0;
                scanning <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/reenc_tracker.sv
// Page re-encryption status tracker (top).
// Allocates entries, sequences cache probes and fetches, flags fills for
// old-counter decryption, and answers demand lookups.
// Assumes the cache answers probe_hit combinationally in the probe cycle.
module reenc_tracker #(
    parameter int N      = rt_pkg::RT_ENTRIES,
    parameter int BLKS   = rt_pkg::RT_BLOCKS,
    parameter int PAGE_W = rt_pkg::RT_PAGE_W,
    parameter int MAJ_W  = rt_pkg::RT_MAJOR_W,
    localparam int IDX_W = $clog2(N),
    localparam int BLK_W = $clog2(BLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [PAGE_W-1:0] alloc_page,
    input  logic [MAJ_W-1:0]  alloc_major,
    output logic              alloc_accept,
    output logic              alloc_stall,
    output logic [IDX_W-1:0]  alloc_slot,
    output logic              probe_valid,
    output logic [PAGE_W-1:0] probe_page,
    output logic [BLK_W-1:0]  probe_blk,
    input  logic              probe_hit,
    output logic              mark_dirty,
    output logic              fetch_issue,
    input  logic              fill_valid,
    input  logic [PAGE_W-1:0] fill_page,
    input  logic [BLK_W-1:0]  fill_blk,
    output logic              fill_redo,
    output logic [IDX_W-1:0]  fill_slot,
    output logic [MAJ_W-1:0]  fill_major,
    input  logic [PAGE_W-1:0] lk_page,
    input  logic [BLK_W-1:0]  lk_blk,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_slot,
    output logic              lk_done,
    output logic [MAJ_W-1:0]  lk_major,
    output logic              lk_wait
);
    logic [N-1:0]             ent_valid;
    logic [N-1:0]             ent_scan;
    logic [N-1:0][PAGE_W-1:0] ent_tag;
    logic [N-1:0][MAJ_W-1:0]  ent_major;
    logic [N-1:0][BLKS-1:0]   ent_done;
    logic [N-1:0][BLK_W-1:0]  ent_ptr;

    logic             free_any, dup_hit, fill_hit;
    logic [IDX_W-1:0] free_idx, dup_idx, probe_sel, rr_q;

    rt_pick #(.N(N), .ROTATE(1'b0)) u_free (
        .req(~ent_valid), .last('0), .any(free_any), .idx(free_idx));

    rt_pick #(.N(N), .ROTATE(1'b1)) u_rr (
        .req(ent_scan), .last(rr_q), .any(probe_valid), .idx(probe_sel));

    rt_match #(.N(N), .TAG_W(PAGE_W)) u_dup (
        .valid(ent_valid), .tags(ent_tag), .key(alloc_page), .hit(dup_hit), .idx(dup_idx));

    rt_match #(.N(N), .TAG_W(PAGE_W)) u_fill (
        .valid(ent_valid), .tags(ent_tag), .key(fill_page), .hit(fill_hit), .idx(fill_slot));

    rt_match #(.N(N), .TAG_W(PAGE_W)) u_look (
        .valid(ent_valid), .tags(ent_tag), .key(lk_page), .hit(lk_hit), .idx(lk_slot));

    // allocation decision: refuse when full or when the page is already tracked
    always_comb begin
        alloc_stall  = alloc_req && (!free_any || dup_hit);
        alloc_accept = alloc_req && free_any && !dup_hit;
        alloc_slot   = free_idx;
    end

    // probe outputs and the cache's verdict on the probed block
    always_comb begin
        probe_page  = ent_tag[probe_sel];
        probe_blk   = ent_ptr[probe_sel];
        mark_dirty  = probe_valid && probe_hit;
        fetch_issue = probe_valid && !probe_hit;
    end

    // fill and demand lookup results
    always_comb begin
        fill_redo  = fill_valid && fill_hit && !ent_done[fill_slot][fill_blk];
        fill_major = ent_major[fill_slot];
        lk_done    = lk_hit && ent_done[lk_slot][lk_blk];
        lk_major   = ent_major[lk_slot];
        lk_wait    = lk_hit && !lk_done;
    end

    // remember the last probed entry for round-robin
    always_ff @(posedge clk) begin
        if (!rst_n)           rr_q <= IDX_W'(N - 1);
        else if (probe_valid) rr_q <= probe_sel;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_ent
            rt_entry #(.BLKS(BLKS), .PAGE_W(PAGE_W), .MAJ_W(MAJ_W)) u_ent (
                .clk        (clk),
                .rst_n      (rst_n),
                .alloc_we   (alloc_accept && free_idx == IDX_W'(i)),
                .alloc_page (alloc_page),
                .alloc_major(alloc_major),
                .probe_go   (probe_valid && probe_sel == IDX_W'(i)),
                .probe_hit  (probe_hit),
                .fill_set   (fill_redo && fill_slot == IDX_W'(i)),
                .fill_blk   (fill_blk),
                .valid      (ent_valid[i]),
                .tag        (ent_tag[i]),
                .major      (ent_major[i]),
                .done       (ent_done[i]),
                .scanning   (ent_scan[i]),
                .ptr        (ent_ptr[i])
            );
        end
    endgenerate

    logic unused_dup;
    assign unused_dup = ^dup_idx;
endmodule

// File: rtl/reenc_tracker_chk.sv
// Assertion checker for reenc_tracker, attached with bind.
// Assumes it sees the top's entry state vectors and handshake outputs.
module reenc_tracker_chk #(
    parameter int N      = 8,
    parameter int BLKS   = 64,
    localparam int IDX_W = $clog2(N),
    localparam int BLK_W = $clog2(BLKS)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    alloc_req,
    input logic                    alloc_accept,
    input logic                    alloc_stall,
    input logic [IDX_W-1:0]        alloc_slot,
    input logic                    fill_redo,
    input logic [IDX_W-1:0]        fill_slot,
    input logic [BLK_W-1:0]        fill_blk,
    input logic                    probe_valid,
    input logic [IDX_W-1:0]        probe_sel,
    input logic [N-1:0]            ent_valid,
    input logic [N-1:0][BLKS-1:0]  ent_done
);
    logic [N-1:0] below_mask;

    // entries with a lower index than the chosen slot
    always_comb begin
        below_mask = '0;
        for (int i = 0; i < N; i++) below_mask[i] = (IDX_W'(i) < alloc_slot);
    end

    p_lowest_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_accept |-> &(ent_valid | ~below_mask));

    p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_accept |-> !ent_valid[alloc_slot]);

    p_alloc_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_accept |=> ent_valid[$past(alloc_slot)]);

    p_fill_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_redo |=> (!ent_valid[$past(fill_slot)] || ent_done[$past(fill_slot)][$past(fill_blk)]));

    p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && (&ent_valid)) |-> alloc_stall);

    p_probe_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> ent_valid[probe_sel]);

    generate
        for (genvar i = 0; i < N; i++) begin : g_rel
            p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ent_valid[i] |-> !(&ent_done[i]));
        end
    endgenerate
endmodule

bind reenc_tracker reenc_tracker_chk #(.N(N), .BLKS(BLKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_req   (alloc_req),
    .alloc_accept(alloc_accept),
    .alloc_stall (alloc_stall),
    .alloc_slot  (alloc_slot),
    .fill_redo   (fill_redo),
    .fill_slot   (fill_slot),
    .fill_blk    (fill_blk),
    .probe_valid (probe_valid),
    .probe_sel   (probe_sel),
    .ent_valid   (ent_valid),
    .ent_done    (ent_done)
);

// File: tb/reenc_tracker_test.sv
`timescale 1ns/1ps
// Directed bench for reenc_tracker: one task per scenario.
module reenc_tracker_test;
    localparam int PAGE_W = 20;
    localparam int MAJ_W  = 64;
    localparam logic [PAGE_W-1:0] PG_A = 20'h00055;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_req = 1'b0;
    logic [PAGE_W-1:0] alloc_page = '0;
    logic [MAJ_W-1:0] alloc_major = '0;
    logic alloc_accept, alloc_stall;
    logic [2:0] alloc_slot;
    logic probe_valid, mark_dirty, fetch_issue, probe_hit;
    logic [PAGE_W-1:0] probe_page;
    logic [5:0] probe_blk;
    logic fill_valid = 1'b0;
    logic [PAGE_W-1:0] fill_page = '0;
    logic [5:0] fill_blk = '0;
    logic fill_redo;
    logic [2:0] fill_slot;
    logic [MAJ_W-1:0] fill_major;
    logic [PAGE_W-1:0] lk_page = '0;
    logic [5:0] lk_blk = '0;
    logic lk_hit, lk_done, lk_wait;
    logic [2:0] lk_slot;
    logic [MAJ_W-1:0] lk_major;

    // bench cache model: one page has a set of present blocks
    logic [PAGE_W-1:0] cached_page = '0;
    logic [63:0] cached_mask = '0;
    assign probe_hit = probe_valid && (probe_page == cached_page) && cached_mask[probe_blk];

    int n_chk = 0, n_fail = 0;
    int cnt_fetch_a = 0, cnt_dirty_a = 0, order_err = 0, exp_blk = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    reenc_tracker uut (.*);

    // monitor probe traffic for page A
    always @(posedge clk) begin
        if (rst_n && probe_valid && probe_page == PG_A) begin
            if (int'(probe_blk) != exp_blk) order_err++;
            exp_blk++;
            if (fetch_issue) cnt_fetch_a++;
            if (mark_dirty)  cnt_dirty_a++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_alloc(input logic [PAGE_W-1:0] pg, input logic [MAJ_W-1:0] mj,
                            output bit acc, output bit stl, output int slot);
        @(negedge clk);
        alloc_req = 1'b1; alloc_page = pg; alloc_major = mj;
        #1;
        acc = alloc_accept; stl = alloc_stall; slot = int'(alloc_slot);
        @(posedge clk);
        @(negedge clk);
        alloc_req = 1'b0;
    endtask

    task automatic look(input logic [PAGE_W-1:0] pg, input int b);
        lk_page = pg; lk_blk = 6'(b);
        #1;
    endtask

    task automatic fill_one(input logic [PAGE_W-1:0] pg, input int b, output bit redo);
        @(negedge clk);
        fill_valid = 1'b1; fill_page = pg; fill_blk = 6'(b);
        #1;
        redo = fill_redo;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 3000 && probe_valid; t++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        look(PG_A, 0);
        chk(!lk_hit, "R10", "lookup after reset", lk_hit, 0);
        chk(!probe_valid, "R3", "no probe after reset", probe_valid, 0);
    endtask

    task automatic t_walk();
        bit acc, stl, redo; int slot;
        cached_page = PG_A;
        for (int b = 0; b < 64; b++) cached_mask[b] = (b % 2 == 0);
        exp_blk = 0; cnt_fetch_a = 0; cnt_dirty_a = 0; order_err = 0;
        do_alloc(PG_A, 64'h1234_5678_9abc_def0, acc, stl, slot);
        chk(acc && !stl, "R2", "first alloc accepted", acc, 1);
        chk(slot == 0, "R1", "first alloc slot", slot, 0);
        look(PG_A, 2);
        chk(lk_hit && lk_slot == 0 && lk_major == 64'h1234_5678_9abc_def0,
            "R10", "lookup returns saved major", lk_major, 64'h1234_5678_9abc_def0);
        chk(!lk_done, "R2", "flags cleared on alloc", lk_done, 0);
        repeat (4) @(negedge clk);
        fill_valid = 1'b1; fill_page = PG_A; fill_blk = 6'd1;
        #1;
        chk(probe_valid && probe_blk == 6'd4 && mark_dirty, "R3", "probe on block 4 in fill cycle",
            probe_blk, 4);
        chk(fill_redo && fill_major == 64'h1234_5678_9abc_def0, "R5", "fill redo with old major",
            fill_redo, 1);
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        look(PG_A, 1);
        chk(lk_done, "R5", "filled block flagged", lk_done, 1);
        look(PG_A, 4);
        chk(lk_done && !lk_wait, "R3", "cached block flagged at probe", lk_done, 1);
        fill_one(PG_A, 1, redo);
        chk(!redo, "R5", "repeat fill ignored", redo, 0);
        fill_one(20'h0ABCD, 3, redo);
        chk(!redo, "R5", "fill for unknown page ignored", redo, 0);
        wait_idle();
        chk(cnt_fetch_a == 32, "R4", "fetches for absent blocks", cnt_fetch_a, 32);
        chk(cnt_dirty_a == 32, "R3", "dirty marks for present blocks", cnt_dirty_a, 32);
        chk(order_err == 0 && exp_blk == 64, "R3", "ascending probe order", exp_blk, 64);
        look(PG_A, 3);
        chk(lk_hit && lk_wait, "R7", "absent block waits", lk_wait, 1);
        chk(!lk_done, "R4", "absent block flag clear", lk_done, 0);
        look(PG_A, 6);
        chk(!lk_wait, "R7", "completed block proceeds", lk_wait, 0);
    endtask

    task automatic t_dup();
        bit acc, stl; int slot;
        do_alloc(PG_A, 64'd7, acc, stl, slot);
        chk(stl && !acc, "R8", "duplicate page stalls", stl, 1);
        look(PG_A, 2);
        chk(lk_major == 64'h1234_5678_9abc_def0, "R8", "stall leaves entry unchanged",
            lk_major, 64'h1234_5678_9abc_def0);
    endtask

    task automatic t_release();
        bit redo;
        for (int b = 3; b < 64; b += 2) fill_one(PG_A, b, redo);
        look(PG_A, 0);
        chk(!lk_hit, "R6", "entry released after last flag", lk_hit, 0);
    endtask

    task automatic t_full_rr();
        bit acc, stl; int slot; bit [7:0] seen; int bad;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            do_alloc(20'h00100 + 20'(i), 64'(100 + i), acc, stl, slot);
            if (!acc || slot != i) bad++;
        end
        chk(bad == 0, "R1", "eight allocs fill slots 0..7", bad, 0);
        do_alloc(20'h00200, 64'd9, acc, stl, slot);
        chk(stl && !acc, "R8", "full tracker stalls", stl, 1);
        look(20'h00200, 0);
        chk(!lk_hit, "R8", "stalled page not tracked", lk_hit, 0);
        repeat (2) @(negedge clk);
        seen = '0;
        for (int k = 0; k < 8; k++) begin
            #1;
            if (probe_valid) seen[probe_page[2:0]] = 1'b1;
            @(negedge clk);
        end
        chk(seen == 8'hFF, "R9", "round-robin covers all entries", seen, 8'hFF);
    endtask

    task automatic t_reuse();
        bit acc, stl, redo; int slot;
        wait_idle();
        for (int b = 0; b < 64; b++) fill_one(20'h00103, b, redo);
        look(20'h00103, 0);
        chk(!lk_hit, "R6", "slot 3 released", lk_hit, 0);
        do_alloc(20'h00300, 64'd555, acc, stl, slot);
        chk(acc && slot == 3, "R1", "reuse lowest free slot", slot, 3);
        look(20'h00300, 5);
        chk(lk_hit && lk_major == 64'd555 && !lk_done, "R2", "reused entry fresh state",
            lk_major, 555);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_walk();
        t_dup();
        t_release();
        t_full_rr();
        t_reuse();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule